// File: doc/BRIEF.md
# Lazy Register Context Migration Unit

This block moves the architectural register context of a running thread from a source core to a destination core on demand rather than in bulk. When the source is switched into its migration mode, it stops issuing its own instructions. It then sends one header transfer that carries three things: the set of live registers, the program counter, and the values of the two highest-numbered registers. After that it only answers register requests that come from the destination.

The destination takes in a stream of instruction register fields: two source indices and one destination index, each with a valid flag. An instruction that reads a register still marked pending is held back. The unit fetches that register from the source over a request/response channel with valid/ready handshakes, one request at a time. An instruction that writes a pending register drops it from the pending set with no transfer, because the old value is dead. Once the pending set is empty, the destination raises a one-cycle completion pulse. The source then goes idle and discards its copy of the context.

Top module: `ctx_migrate_lazy`

## Requirements
- R1: After reset the source accepts local register writes (`src_issue_ready`=1), is not idle, the pending set is all zero, the destination refuses instructions (`dst_ins_ready`=0), and no completion pulse or request is seen.
- R2: One cycle of `src_start` blocks local writes on the source. Before any register request, the destination then holds the captured program counter (`dst_pc`) and the source's values of registers 30 and 31. Its pending set equals the source's written-register set with bits 30 and 31 cleared.
- R3: For an instruction whose valid source index names a pending register, a request for that index appears on `xfer_req_fire`/`xfer_req_idx`. The destination register file then holds the source's value for that index.
- R4: When both source operands of one instruction are pending and differ, the lower index is requested first and the other is requested only afterwards.
- R5: An instruction with a pending source operand is not accepted (`dst_ins_ready`=0) until every such operand has been written into the destination register file.
- R6: A register is requested at most once per migration. A later read of a received register causes no request and no stall.
- R7: Accepting an instruction whose valid destination index names a pending register clears that bit with no request.
- R8: If an instruction reads and writes the same pending register, that register is transferred first (its source value is visible at the destination) and only then is it removed from pending.
- R9: When the pending set becomes empty, `mig_done` is high for exactly one cycle, also when the header brings an empty set. On the next cycle `src_idle` is 1. The source then stays unable to issue, and the destination accepts every instruction.
- R10: The source answers an accepted request one cycle later. The pending bit of the requested register is still set one cycle after the request and clear two cycles after it.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_start | input | 1 | Put the source into migration mode |
| src_pc | input | 64 | Program counter captured at start |
| src_wr_en | input | 1 | Local register write at the source |
| src_wr_idx | input | 5 | Local write index |
| src_wr_data | input | 64 | Local write value |
| src_issue_ready | output | 1 | Source accepts local writes |
| src_idle | output | 1 | Source has handed off and invalidated its context |
| dst_ins_valid | input | 1 | Instruction presented to the destination |
| dst_ins_ready | output | 1 | Destination accepts the instruction |
| dst_rs1_valid | input | 1 | First source index is used |
| dst_rs1 | input | 5 | First source index |
| dst_rs2_valid | input | 1 | Second source index is used |
| dst_rs2 | input | 5 | Second source index |
| dst_rd_valid | input | 1 | Destination index is written |
| dst_rd | input | 5 | Destination index |
| dst_pc | output | 64 | Program counter received in the header |
| dst_pending | output | 32 | Registers still owed by the source |
| dst_peek_idx | input | 5 | Destination register file read index |
| dst_peek_data | output | 64 | Destination register file read value |
| mig_done | output | 1 | One-cycle completion pulse |
| xfer_req_fire | output | 1 | A register request is handed over this cycle |
| xfer_req_idx | output | 5 | Index of that request |

## Verification
A pending bit that is wrongly left set shows up as an instruction that never becomes ready, or as a completion pulse that never arrives. A bit that is wrongly cleared shows up one peek later as a destination register that lacks the source value. A lost response or a doubled request shows up in the request log within two cycles of the instruction that caused it. A wrong source state shows up in `src_issue_ready` and `src_idle` on the cycle after the header or the completion.

// File: rtl/ctx_mig_pkg.sv
package ctx_mig_pkg;
  localparam int unsigned REG_COUNT = 32;
  localparam int unsigned REG_WIDTH = 64;

  typedef enum logic [1:0] {
    SRC_NORMAL = 2'd0,
    SRC_HEADER = 2'd1,
    SRC_SERVE  = 2'd2,
    SRC_IDLE   = 2'd3
  } src_state_e;

  typedef enum logic [1:0] {
    DST_WAIT_HDR = 2'd0,
    DST_FETCH    = 2'd1,
    DST_OWNED    = 2'd2
  } dst_state_e;
endpackage

// File: rtl/ctx_mig_rf.sv
module ctx_mig_rf #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 64,
  parameter int unsigned NRD   = 1,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wa_en,
  input  logic [IW-1:0]    wa_idx,
  input  logic [WIDTH-1:0] wa_data,
  input  logic             wb_en,
  input  logic [IW-1:0]    wb_idx,
  input  logic [WIDTH-1:0] wb_data,
  input  logic [IW-1:0]    rd_idx  [NRD],
  output logic [WIDTH-1:0] rd_data [NRD]
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  // Port b wins when both ports hit the same entry.
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic             hit_a;
    logic             hit_b;
    logic             ent_en;
    logic [WIDTH-1:0] ent_d;
    always_comb begin
      hit_a  = wa_en && (wa_idx == IW'(e));
      hit_b  = wb_en && (wb_idx == IW'(e));
      ent_en = hit_a || hit_b;
      ent_d  = hit_b ? wb_data : wa_data;
    end
    always_ff @(posedge clk) begin
      if (ent_en) mem_q[e] <= ent_d;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_read
    assign rd_data[r] = mem_q[rd_idx[r]];
  end
endmodule

// File: rtl/ctx_mig_src.sv
module ctx_mig_src
  import ctx_mig_pkg::*;
#(
  parameter int unsigned DEPTH = REG_COUNT,
  parameter int unsigned WIDTH = REG_WIDTH,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] pc_i,
  input  logic             loc_wr_en_i,
  input  logic [IW-1:0]    loc_wr_idx_i,
  input  logic [WIDTH-1:0] loc_wr_data_i,
  output logic             issue_ready_o,
  output logic             idle_o,
  output logic             hdr_valid_o,
  input  logic             hdr_ready_i,
  output logic [DEPTH-1:0] hdr_map_o,
  output logic [WIDTH-1:0] hdr_pc_o,
  output logic [WIDTH-1:0] hdr_hi0_o,
  output logic [WIDTH-1:0] hdr_hi1_o,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [IW-1:0]    req_idx_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [IW-1:0]    rsp_idx_o,
  output logic [WIDTH-1:0] rsp_data_o,
  input  logic             done_i
);
  localparam logic [IW-1:0] HI0 = IW'(DEPTH - 2);
  localparam logic [IW-1:0] HI1 = IW'(DEPTH - 1);

  src_state_e       st_q, st_d;
  logic [DEPTH-1:0] used_q, used_d;
  logic [WIDTH-1:0] pc_q;
  logic             pc_en;
  logic             rsp_v_q, rsp_v_d;
  logic [IW-1:0]    rsp_i_q;
  logic [WIDTH-1:0] rsp_d_q;
  logic             req_fire, loc_fire;
  logic [IW-1:0]    rd_idx  [3];
  logic [WIDTH-1:0] rd_data [3];

  ctx_mig_rf #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NRD(3)) u_rf (
    .clk     (clk),
    .wa_en   (loc_fire),
    .wa_idx  (loc_wr_idx_i),
    .wa_data (loc_wr_data_i),
    .wb_en   (1'b0),
    .wb_idx  ('0),
    .wb_data ('0),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  always_comb begin
    rd_idx[0] = req_idx_i;
    rd_idx[1] = HI0;
    rd_idx[2] = HI1;
    issue_ready_o = (st_q == SRC_NORMAL);
    idle_o        = (st_q == SRC_IDLE);
    hdr_valid_o   = (st_q == SRC_HEADER);
    hdr_map_o     = used_q;
    hdr_pc_o      = pc_q;
    hdr_hi0_o     = rd_data[1];
    hdr_hi1_o     = rd_data[2];
    req_ready_o   = (st_q == SRC_SERVE) && (!rsp_v_q || rsp_ready_i);
    req_fire      = req_valid_i && req_ready_o;
    loc_fire      = issue_ready_o && loc_wr_en_i;
    pc_en         = issue_ready_o && start_i;
    rsp_valid_o   = rsp_v_q;
    rsp_idx_o     = rsp_i_q;
    rsp_data_o    = rsp_d_q;
  end

  always_comb begin
    st_d   = st_q;
    used_d = used_q;
    unique case (st_q)
      SRC_NORMAL: if (start_i) st_d = SRC_HEADER;
      SRC_HEADER: if (hdr_ready_i) st_d = SRC_SERVE;
      SRC_SERVE: if (done_i) begin
        st_d   = SRC_IDLE;
        used_d = '0;
      end
      default: st_d = SRC_IDLE;
    endcase
    if (loc_fire) used_d[loc_wr_idx_i] = 1'b1;
  end

  always_comb begin
    rsp_v_d = rsp_v_q;
    if (req_fire) rsp_v_d = 1'b1;
    else if (rsp_v_q && rsp_ready_i) rsp_v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SRC_NORMAL;
      used_q  <= '0;
      rsp_v_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      used_q  <= used_d;
      rsp_v_q <= rsp_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pc_en) pc_q <= pc_i;
    if (req_fire) begin
      rsp_i_q <= req_idx_i;
      rsp_d_q <= rd_data[0];
    end
  end
endmodule

// File: rtl/ctx_mig_dst.sv
module ctx_mig_dst
  import ctx_mig_pkg::*;
#(
  parameter int unsigned DEPTH = REG_COUNT,
  parameter int unsigned WIDTH = REG_WIDTH,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_valid_i,
  output logic             hdr_ready_o,
  input  logic [DEPTH-1:0] hdr_map_i,
  input  logic [WIDTH-1:0] hdr_pc_i,
  input  logic [WIDTH-1:0] hdr_hi0_i,
  input  logic [WIDTH-1:0] hdr_hi1_i,
  input  logic             ins_valid_i,
  output logic             ins_ready_o,
  input  logic             rs1_v_i,
  input  logic [IW-1:0]    rs1_i,
  input  logic             rs2_v_i,
  input  logic [IW-1:0]    rs2_i,
  input  logic             rd_v_i,
  input  logic [IW-1:0]    rd_i,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [IW-1:0]    req_idx_o,
  input  logic             rsp_valid_i,
  output logic             rsp_ready_o,
  input  logic [IW-1:0]    rsp_idx_i,
  input  logic [WIDTH-1:0] rsp_data_i,
  output logic             done_o,
  output logic [DEPTH-1:0] pend_o,
  output logic [WIDTH-1:0] pc_o,
  input  logic [IW-1:0]    peek_idx_i,
  output logic [WIDTH-1:0] peek_data_o
);
  localparam logic [IW-1:0]    HI0   = IW'(DEPTH - 2);
  localparam logic [IW-1:0]    HI1   = IW'(DEPTH - 1);
  localparam logic [DEPTH-1:0] EAGER = {2'b11, {(DEPTH-2){1'b0}}};

  dst_state_e       st_q, st_d;
  logic [DEPTH-1:0] pend_q, pend_d;
  logic             wait_q, wait_d;
  logic [WIDTH-1:0] pc_q;
  logic             hdr_fire, rsp_fire, req_fire, ins_fire;
  logic             need1, need2, fetching;
  logic             wa_en;
  logic [IW-1:0]    wa_idx;
  logic [WIDTH-1:0] wa_data;
  logic [IW-1:0]    pk_idx  [1];
  logic [WIDTH-1:0] pk_data [1];

  ctx_mig_rf #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NRD(1)) u_rf (
    .clk     (clk),
    .wa_en   (wa_en),
    .wa_idx  (wa_idx),
    .wa_data (wa_data),
    .wb_en   (hdr_fire),
    .wb_idx  (HI1),
    .wb_data (hdr_hi1_i),
    .rd_idx  (pk_idx),
    .rd_data (pk_data)
  );

  always_comb begin
    fetching    = (st_q == DST_FETCH);
    hdr_ready_o = (st_q == DST_WAIT_HDR);
    hdr_fire    = hdr_valid_i && hdr_ready_o;
    rsp_ready_o = 1'b1;
    rsp_fire    = rsp_valid_i && wait_q;
    need1       = rs1_v_i && pend_q[rs1_i];
    need2       = rs2_v_i && pend_q[rs2_i];
    // Lower index goes first when both operands are owed.
    if (need1 && need2) req_idx_o = (rs1_i < rs2_i) ? rs1_i : rs2_i;
    else if (need1)     req_idx_o = rs1_i;
    else                req_idx_o = rs2_i;
    req_valid_o = fetching && ins_valid_i && (need1 || need2) && !wait_q;
    req_fire    = req_valid_o && req_ready_i;
    ins_ready_o = (fetching && !need1 && !need2 && !wait_q) || (st_q == DST_OWNED);
    ins_fire    = ins_valid_i && ins_ready_o;
    done_o      = fetching && (pend_q == '0) && !wait_q;
    wa_en       = hdr_fire || rsp_fire;
    wa_idx      = hdr_fire ? HI0 : rsp_idx_i;
    wa_data     = hdr_fire ? hdr_hi0_i : rsp_data_i;
    pk_idx[0]   = peek_idx_i;
    peek_data_o = pk_data[0];
    pend_o      = pend_q;
    pc_o        = pc_q;
  end

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    wait_d = wait_q;
    unique case (st_q)
      DST_WAIT_HDR: if (hdr_fire) begin
        st_d   = DST_FETCH;
        pend_d = hdr_map_i & ~EAGER;
      end
      DST_FETCH: begin
        if (done_o) st_d = DST_OWNED;
        if (req_fire) wait_d = 1'b1;
        if (rsp_fire) begin
          wait_d = 1'b0;
          pend_d[rsp_idx_i] = 1'b0;
        end
        // A write retires the old value: nothing to fetch for it.
        if (ins_fire && rd_v_i) pend_d[rd_i] = 1'b0;
      end
      default: st_d = DST_OWNED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DST_WAIT_HDR;
      pend_q <= '0;
      wait_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      wait_q <= wait_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hdr_fire) pc_q <= hdr_pc_i;
  end
endmodule

// File: rtl/ctx_migrate_lazy.sv
module ctx_migrate_lazy
  import ctx_mig_pkg::*;
#(
  parameter int unsigned DEPTH = REG_COUNT,
  parameter int unsigned WIDTH = REG_WIDTH,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_start,
  input  logic [WIDTH-1:0] src_pc,
  input  logic             src_wr_en,
  input  logic [IW-1:0]    src_wr_idx,
  input  logic [WIDTH-1:0] src_wr_data,
  output logic             src_issue_ready,
  output logic             src_idle,
  input  logic             dst_ins_valid,
  output logic             dst_ins_ready,
  input  logic             dst_rs1_valid,
  input  logic [IW-1:0]    dst_rs1,
  input  logic             dst_rs2_valid,
  input  logic [IW-1:0]    dst_rs2,
  input  logic             dst_rd_valid,
  input  logic [IW-1:0]    dst_rd,
  output logic [WIDTH-1:0] dst_pc,
  output logic [DEPTH-1:0] dst_pending,
  input  logic [IW-1:0]    dst_peek_idx,
  output logic [WIDTH-1:0] dst_peek_data,
  output logic             mig_done,
  output logic             xfer_req_fire,
  output logic [IW-1:0]    xfer_req_idx
);
  logic             hdr_valid, hdr_ready;
  logic [DEPTH-1:0] hdr_map;
  logic [WIDTH-1:0] hdr_pc, hdr_hi0, hdr_hi1;
  logic             req_valid, req_ready;
  logic [IW-1:0]    req_idx;
  logic             rsp_valid, rsp_ready;
  logic [IW-1:0]    rsp_idx;
  logic [WIDTH-1:0] rsp_data;

  ctx_mig_src #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_src (
    .clk (clk), .rst_n (rst_n),
    .start_i (src_start), .pc_i (src_pc),
    .loc_wr_en_i (src_wr_en), .loc_wr_idx_i (src_wr_idx), .loc_wr_data_i (src_wr_data),
    .issue_ready_o (src_issue_ready), .idle_o (src_idle),
    .hdr_valid_o (hdr_valid), .hdr_ready_i (hdr_ready), .hdr_map_o (hdr_map),
    .hdr_pc_o (hdr_pc), .hdr_hi0_o (hdr_hi0), .hdr_hi1_o (hdr_hi1),
    .req_valid_i (req_valid), .req_ready_o (req_ready), .req_idx_i (req_idx),
    .rsp_valid_o (rsp_valid), .rsp_ready_i (rsp_ready),
    .rsp_idx_o (rsp_idx), .rsp_data_o (rsp_data),
    .done_i (mig_done)
  );

  ctx_mig_dst #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dst (
    .clk (clk), .rst_n (rst_n),
    .hdr_valid_i (hdr_valid), .hdr_ready_o (hdr_ready), .hdr_map_i (hdr_map),
    .hdr_pc_i (hdr_pc), .hdr_hi0_i (hdr_hi0), .hdr_hi1_i (hdr_hi1),
    .ins_valid_i (dst_ins_valid), .ins_ready_o (dst_ins_ready),
    .rs1_v_i (dst_rs1_valid), .rs1_i (dst_rs1),
    .rs2_v_i (dst_rs2_valid), .rs2_i (dst_rs2),
    .rd_v_i (dst_rd_valid), .rd_i (dst_rd),
    .req_valid_o (req_valid), .req_ready_i (req_ready), .req_idx_o (req_idx),
    .rsp_valid_i (rsp_valid), .rsp_ready_o (rsp_ready),
    .rsp_idx_i (rsp_idx), .rsp_data_i (rsp_data),
    .done_o (mig_done), .pend_o (dst_pending), .pc_o (dst_pc),
    .peek_idx_i (dst_peek_idx), .peek_data_o (dst_peek_data)
  );

  assign xfer_req_fire = req_valid && req_ready;
  assign xfer_req_idx  = req_idx;
endmodule

// File: rtl/ctx_migrate_lazy_chk.sv
module ctx_migrate_lazy_chk #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [IW-1:0]    req_idx,
  input logic             rsp_valid,
  input logic [DEPTH-1:0] pend,
  input logic             ins_valid,
  input logic             ins_ready,
  input logic             rs1_v,
  input logic [IW-1:0]    rs1,
  input logic             rs2_v,
  input logic [IW-1:0]    rs2,
  input logic             done,
  input logic             src_issue_ready,
  input logic             src_idle
);
  assert_req_only_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> pend[req_idx]);

  assert_rsp_next_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_no_issue_with_owed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready) |-> !(rs1_v && pend[rs1]) && !(rs2_v && pend[rs2]));

  assert_lower_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && rs1_v && rs2_v && pend[rs1] && pend[rs2] && rs1 != rs2)
      |-> (req_idx == ((rs1 < rs2) ? rs1 : rs2)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_idle) |-> $past(done));

  assert_idle_blocks_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    src_idle |-> !src_issue_ready);
endmodule

bind ctx_migrate_lazy ctx_migrate_lazy_chk #(.DEPTH(DEPTH)) u_chk (
  .clk (clk), .rst_n (rst_n),
  .req_valid (req_valid), .req_ready (req_ready), .req_idx (req_idx),
  .rsp_valid (rsp_valid), .pend (dst_pending),
  .ins_valid (dst_ins_valid), .ins_ready (dst_ins_ready),
  .rs1_v (dst_rs1_valid), .rs1 (dst_rs1),
  .rs2_v (dst_rs2_valid), .rs2 (dst_rs2),
  .done (mig_done), .src_issue_ready (src_issue_ready), .src_idle (src_idle)
);

// File: tb/ctx_migrate_lazy_test.sv
module ctx_migrate_lazy_test;
  logic        clk;
  logic        rst_n;
  logic        src_start;
  logic [63:0] src_pc;
  logic        src_wr_en;
  logic [4:0]  src_wr_idx;
  logic [63:0] src_wr_data;
  logic        src_issue_ready, src_idle;
  logic        dst_ins_valid, dst_ins_ready;
  logic        dst_rs1_valid, dst_rs2_valid, dst_rd_valid;
  logic [4:0]  dst_rs1, dst_rs2, dst_rd;
  logic [63:0] dst_pc;
  logic [31:0] dst_pending;
  logic [4:0]  dst_peek_idx;
  logic [63:0] dst_peek_data;
  logic        mig_done, xfer_req_fire;
  logic [4:0]  xfer_req_idx;

  int n_chk, n_bad, n_req, n_done, cyc;
  logic [4:0] req_log [64];

  ctx_migrate_lazy uut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] sval(input int i);
    return 64'h0123_4567_89AB_CDEF ^ {16'hBEEF, 8'(i), 40'h0};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && xfer_req_fire) begin
      if (n_req < 64) req_log[n_req] = xfer_req_idx;
      n_req++;
    end
    if (rst_n && mig_done) n_done++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic do_reset;
    rst_n = 1'b0; src_start = 0; src_pc = '0; src_wr_en = 0; src_wr_idx = '0; src_wr_data = '0;
    dst_ins_valid = 0; dst_rs1_valid = 0; dst_rs2_valid = 0; dst_rd_valid = 0;
    dst_rs1 = '0; dst_rs2 = '0; dst_rd = '0; dst_peek_idx = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    n_req = 0; n_done = 0;
  endtask

  task automatic src_write(input int idx);
    @(posedge clk) #2;
    src_wr_en = 1; src_wr_idx = 5'(idx); src_wr_data = sval(idx);
    @(posedge clk) #2 src_wr_en = 0;
  endtask

  task automatic start_mig(input logic [63:0] pc);
    @(posedge clk) #2; src_start = 1; src_pc = pc;
    @(posedge clk) #2; src_start = 0; src_pc = '0;
    repeat (3) @(negedge clk);
  endtask

  // Presents one instruction and waits for its acceptance; returns stall cycles.
  task automatic issue(input logic v1, input int a, input logic v2, input int b,
                       input logic vd, input int d, output int stalls);
    stalls = 0;
    @(posedge clk) #2;
    dst_ins_valid = 1; dst_rs1_valid = v1; dst_rs1 = 5'(a);
    dst_rs2_valid = v2; dst_rs2 = 5'(b); dst_rd_valid = vd; dst_rd = 5'(d);
    @(negedge clk);
    while (!dst_ins_ready && stalls < 50) begin
      stalls++;
      @(negedge clk);
    end
    @(posedge clk) #2;
    dst_ins_valid = 0; dst_rs1_valid = 0; dst_rs2_valid = 0; dst_rd_valid = 0;
    @(negedge clk);
  endtask

  task automatic peek(input int idx, input string req);
    dst_peek_idx = 5'(idx);
    #1 check(req, dst_peek_data, sval(idx));
  endtask

  task automatic setup(input logic [63:0] pc);
    do_reset();
    src_write(3); src_write(7); src_write(9); src_write(12); src_write(30); src_write(31);
    start_mig(pc);
  endtask

  task automatic t_reset;
    do_reset();
    check("R1 src_issue_ready", src_issue_ready, 1);
    check("R1 src_idle", src_idle, 0);
    check("R1 pending", dst_pending, 0);
    check("R1 ins_ready", dst_ins_ready, 0);
    check("R1 done/req", {mig_done, xfer_req_fire}, 0);
  endtask

  task automatic t_header;
    setup(64'h0000_4000_1234_5678);
    check("R2 issue blocked", src_issue_ready, 0);
    check("R2 pc", dst_pc, 64'h0000_4000_1234_5678);
    peek(30, "R2 reg30"); peek(31, "R2 reg31");
    check("R2 pending map", dst_pending, 32'h0000_1288);
    check("R2 no request yet", n_req, 0);
  endtask

  task automatic t_single;
    setup(64'h10);
    @(posedge clk) #2;
    dst_ins_valid = 1; dst_rs1_valid = 1; dst_rs1 = 5'd3;
    @(negedge clk);
    check("R3 request fire", {xfer_req_fire, 3'b0, xfer_req_idx}, {1'b1, 3'b0, 5'd3});
    check("R5 stalled", dst_ins_ready, 0);
    @(negedge clk);
    check("R10 pending one cycle after", dst_pending[3], 1);
    check("R5 still stalled", dst_ins_ready, 0);
    @(negedge clk);
    check("R10 pending two cycles after", dst_pending[3], 0);
    check("R5 released", dst_ins_ready, 1);
    peek(3, "R3 value 3");
    @(posedge clk) #2; dst_ins_valid = 0; dst_rs1_valid = 0;
    @(negedge clk);
  endtask

  task automatic t_order;
    int st;
    setup(64'h20);
    issue(1, 7, 1, 3, 0, 0, st);
    check("R4 request count", n_req, 2);
    check("R4 first lower", req_log[0], 3);
    check("R4 second higher", req_log[1], 7);
    peek(3, "R3 value 3"); peek(7, "R3 value 7");
    issue(1, 3, 1, 7, 0, 0, st);
    check("R6 no re-request", n_req, 2);
    check("R6 no stall", st, 0);
  endtask

  task automatic t_overwrite;
    int st;
    setup(64'h30);
    issue(0, 0, 0, 0, 1, 9, st);
    check("R7 no request", n_req, 0);
    check("R7 pending cleared", dst_pending, 32'h0000_1088);
    issue(1, 7, 0, 0, 1, 7, st);
    check("R8 transfer made", n_req, 1);
    check("R8 index", req_log[0], 7);
    peek(7, "R8 value");
    check("R8 cleared", dst_pending[7], 0);
  endtask

  task automatic t_done;
    int st;
    setup(64'h40);
    issue(1, 3, 0, 0, 0, 0, st);
    issue(0, 0, 0, 0, 1, 9, st);
    check("R9 no early done", n_done, 0);
    issue(1, 12, 1, 12, 0, 0, st);
    check("R6 same reg once", n_req, 2);
    issue(0, 0, 0, 0, 1, 7, st);
    repeat (3) @(negedge clk);
    check("R9 one pulse", n_done, 1);
    check("R9 src idle", src_idle, 1);
    check("R9 issue blocked", src_issue_ready, 0);
    check("R9 dst owns", dst_ins_ready, 1);
  endtask

  task automatic t_empty;
    do_reset();
    src_write(30);
    start_mig(64'h50);
    check("R9 empty done", n_done, 1);
    check("R9 empty idle", src_idle, 1);
    check("R9 empty no req", n_req, 0);
    peek(30, "R2 reg30 empty");
  endtask

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0;
    t_reset();
    t_header();
    t_single();
    t_order();
    t_overwrite();
    t_done();
    t_empty();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule